// File: doc/BRIEF.md
# Buffered RTC Register Access Port

This block sits between a byte-level serial transaction engine and the timekeeping register file of a real-time clock. The transaction engine supplies abstract strobes: transaction start, transaction stop, pointer load, byte received, byte acknowledged and byte consumed by a read. The bit-level bus signalling stays in that engine. This block keeps the register pointer, serves read data, and issues write commits to the register file.

Reads of the time/date registers come from a shadow copy, not from the live counters. The shadow is reloaded from the live values only at transaction boundaries and when the pointer wraps. A multi-byte read therefore returns one coherent snapshot, even while the seconds counter ticks underneath it. The remaining registers, such as the alarms, are read live. A received byte is committed to the register file in the cycle of its acknowledge. A commit to the seconds register also produces a reset pulse for the sub-second divider chain.

Top module: `rtc_buf_port`

## Requirements
- R1: After reset the pointer is 0. The shadow holds 00h. No write is pending. rdata_o reads 00h and wr_en_o and div_rst_o are low.
- R2: When addr_load_i is high, the pointer takes data_i[ADDR_W-1:0] at the next clock edge. rdata_o always presents the byte at the current pointer. A pointer load has priority over an increment in the same cycle.
- R3: For addresses 0 to N_TIME-1, rdata_o returns the shadow copy. Changes on live_i do not reach rdata_o until a refresh occurs.
- R4: At a clock edge where start_i or stop_i is high, every shadow byte is loaded from live_i bytes 0 to N_TIME-1.
- R5: The pointer advances by one after each rd_byte_i strobe and after each committed write. From N_REG-1 it wraps to 0, and from 2^ADDR_W-1 it also wraps to 0. Any advance that lands on 0 refreshes the shadow at that same edge.
- R6: wr_byte_i captures data_i as a pending byte and produces no write. The write is committed by the next ack_i: wr_en_o is high in that cycle, with wr_addr_o equal to the pointer and wr_data_o equal to the pending byte.
- R7: A commit to address 0 drives div_rst_o high in the same cycle. div_rst_o is otherwise low.
- R8: At a pointer of N_REG or above, rdata_o reads 00h. A commit there leaves wr_en_o low, but the pointer still advances.
- R9: For addresses N_TIME to N_REG-1, rdata_o follows live_i directly in the same cycle.
- R10: An ack_i with no pending byte produces no write and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transaction start strobe |
| stop_i | input | 1 | Transaction stop strobe |
| addr_load_i | input | 1 | Load pointer from data_i |
| wr_byte_i | input | 1 | Byte received for writing |
| ack_i | input | 1 | Acknowledge strobe, commits pending byte |
| rd_byte_i | input | 1 | Read byte consumed, advance pointer |
| data_i | input | 8 | Incoming byte |
| rdata_o | output | 8 | Byte at the current pointer |
| live_i | input | N_REG*8 | Live register file, byte k at bits 8k+7:8k |
| wr_en_o | output | 1 | Write commit to register file |
| wr_addr_o | output | ADDR_W | Commit address |
| wr_data_o | output | 8 | Commit data |
| div_rst_o | output | 1 | Sub-second divider reset pulse |

## Verification
The bench builds the block with N_TIME=7 and N_REG=14, and narrows ADDR_W to 4. The gap of unimplemented addresses then holds only two entries, 14 and 15. A single read can therefore reach the wrap from the top of the pointer range, as well as the ignored writes and zero reads of that gap. live_i changes on every cycle, so any read that bypasses the shadow, or any refresh missing on start, stop or wrap, shows up as a mismatch at once.

// File: rtl/rtc_buf_pkg.sv
package rtc_buf_pkg;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/rtc_buf_ptr.sv
module rtc_buf_ptr #(
  parameter int ADDR_W = 8,
  parameter int N_REG  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              wrap_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_REG - 1);
  localparam logic [ADDR_W-1:0] MAXP = '1;

  logic [ADDR_W-1:0] ptr_q, nxt;

  always_comb begin
    nxt = (ptr_q == LAST || ptr_q == MAXP) ? '0 : ptr_q + 1'b1;
  end

  assign wrap_o = adv_i & ~load_i & (nxt == '0);
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (adv_i)  ptr_q <= nxt;
  end
endmodule

// File: rtl/rtc_buf_wr.sv
module rtc_buf_wr
  import rtc_buf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_REG  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_byte_i,
  input  logic              ack_i,
  input  byte_t             data_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              commit_o,
  output logic              wr_en_o,
  output byte_t             wr_data_o,
  output logic              div_rst_o
);
  logic  pend_q;
  byte_t pend_d_q;

  assign commit_o  = ack_i & pend_q;
  assign wr_en_o   = commit_o & (ptr_i < ADDR_W'(N_REG));
  assign div_rst_o = commit_o & (ptr_i == '0);
  assign wr_data_o = pend_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      pend_d_q <= '0;
    end else if (wr_byte_i) begin
      pend_q   <= 1'b1;
      pend_d_q <= data_i;
    end else if (ack_i) begin
      pend_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_buf_shadow.sv
module rtc_buf_shadow #(
  parameter int N_TIME = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                refresh_i,
  input  logic [N_TIME*8-1:0] live_i,
  output logic [N_TIME*8-1:0] sh_o
);
  for (genvar g = 0; g < N_TIME; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sh_o[g*8 +: 8] <= '0;
      else if (refresh_i) sh_o[g*8 +: 8] <= live_i[g*8 +: 8];
    end
  end
endmodule

// File: rtl/rtc_buf_port.sv
module rtc_buf_port
  import rtc_buf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_TIME = 7,
  parameter int N_REG  = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               addr_load_i,
  input  logic               wr_byte_i,
  input  logic               ack_i,
  input  logic               rd_byte_i,
  input  logic [7:0]         data_i,
  output logic [7:0]         rdata_o,
  input  logic [N_REG*8-1:0] live_i,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [7:0]         wr_data_o,
  output logic               div_rst_o
);
  localparam int IDX_W = $clog2(N_REG);

  logic [ADDR_W-1:0]   ptr_q;
  logic                wrap, commit, refresh;
  logic [N_TIME*8-1:0] sh_flat;
  byte_t               rd_tbl [N_REG];
  logic [IDX_W-1:0]    idx;

  assign refresh = start_i | stop_i | wrap;

  rtc_buf_ptr #(.ADDR_W(ADDR_W), .N_REG(N_REG)) u_ptr (
    .clk_i, .rst_ni,
    .load_i    (addr_load_i),
    .load_val_i(data_i[ADDR_W-1:0]),
    .adv_i     (rd_byte_i | commit),
    .ptr_o     (ptr_q),
    .wrap_o    (wrap)
  );

  rtc_buf_wr #(.ADDR_W(ADDR_W), .N_REG(N_REG)) u_wr (
    .clk_i, .rst_ni,
    .wr_byte_i, .ack_i, .data_i,
    .ptr_i    (ptr_q),
    .commit_o (commit),
    .wr_en_o, .wr_data_o, .div_rst_o
  );

  rtc_buf_shadow #(.N_TIME(N_TIME)) u_sh (
    .clk_i, .rst_ni,
    .refresh_i(refresh),
    .live_i   (live_i[N_TIME*8-1:0]),
    .sh_o     (sh_flat)
  );

  for (genvar g = 0; g < N_REG; g++) begin : g_tbl
    if (g < N_TIME) begin : g_sh
      assign rd_tbl[g] = sh_flat[g*8 +: 8];
    end else begin : g_live
      assign rd_tbl[g] = live_i[g*8 +: 8];
    end
  end

  assign idx       = IDX_W'(ptr_q);
  assign rdata_o   = (ptr_q < ADDR_W'(N_REG)) ? rd_tbl[idx] : 8'h00;
  assign wr_addr_o = ptr_q;
endmodule

// File: rtl/rtc_buf_port_chk.sv
module rtc_buf_port_chk #(
  parameter int ADDR_W = 8,
  parameter int N_TIME = 7,
  parameter int N_REG  = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ack_i,
  input logic                rd_byte_i,
  input logic                addr_load_i,
  input logic                wr_en_o,
  input logic [ADDR_W-1:0]   wr_addr_o,
  input logic                div_rst_o,
  input logic [7:0]          rdata_o,
  input logic [ADDR_W-1:0]   ptr_q,
  input logic                wrap,
  input logic                refresh,
  input logic [N_TIME*8-1:0] sh_flat
);
  assert_wr_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o < ADDR_W'(N_REG)));

  assert_wr_on_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ack_i);

  assert_div_rst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_rst_o |-> (ack_i && wr_addr_o == '0));

  assert_shadow_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !refresh |=> $stable(sh_flat));

  assert_ptr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_byte_i && !addr_load_i && !wrap) |=> (ptr_q == $past(ptr_q) + 1'b1));

  assert_unimpl_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q >= ADDR_W'(N_REG)) |-> (rdata_o == 8'h00));
endmodule

bind rtc_buf_port rtc_buf_port_chk #(.ADDR_W(ADDR_W), .N_TIME(N_TIME), .N_REG(N_REG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .rd_byte_i(rd_byte_i),
  .addr_load_i(addr_load_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
  .div_rst_o(div_rst_o), .rdata_o(rdata_o), .ptr_q(ptr_q), .wrap(wrap),
  .refresh(refresh), .sh_flat(sh_flat)
);

// File: tb/rtc_buf_port_bench.sv
`timescale 1ns/1ps
module rtc_buf_port_bench;
  localparam int AW = 4;
  localparam int NT = 7;
  localparam int NR = 14;
  localparam int MAXP = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start, stop, ld, wb, ak, rb;
  logic [7:0] din;
  logic [7:0] rdata;
  logic [NR*8-1:0] live;
  logic wen, divr;
  logic [AW-1:0] waddr;
  logic [7:0] wdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_ptr = 0;
  int m_sh [NT];
  int m_live [NR];
  bit m_pend = 1'b0;
  int m_pd = 0;

  always #2.5 clk = ~clk;

  rtc_buf_port #(.ADDR_W(AW), .N_TIME(NT), .N_REG(NR)) u_rtc_buf_port (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .addr_load_i(ld), .wr_byte_i(wb), .ack_i(ak), .rd_byte_i(rb),
    .data_i(din), .rdata_o(rdata), .live_i(live), .wr_en_o(wen),
    .wr_addr_o(waddr), .wr_data_o(wdata), .div_rst_o(divr)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, then advance the model at posedge
  task automatic step(input bit s, input bit p, input bit l, input bit w,
                      input bit a, input bit r, input int d, input string tag);
    bit commit, adv;
    int nxt;
    @(negedge clk);
    start = s; stop = p; ld = l; wb = w; ak = a; rb = r; din = 8'(d);
    for (int k = 0; k < NR; k++) begin
      m_live[k] = int'($urandom_range(255));
      live[k*8 +: 8] = 8'(m_live[k]);
    end
    #1;
    commit = a && m_pend;
    cmp(tag, "rdata", int'(rdata),
        (m_ptr < NT) ? m_sh[m_ptr] : (m_ptr < NR) ? m_live[m_ptr] : 0);
    cmp(tag, "wr_en", int'(wen), int'(commit && m_ptr < NR));
    cmp(tag, "div_rst", int'(divr), int'(commit && m_ptr == 0));
    if (commit && m_ptr < NR) begin
      cmp(tag, "wr_addr", int'(waddr), m_ptr);
      cmp(tag, "wr_data", int'(wdata), m_pd);
    end
    @(posedge clk);
    adv = r || commit;
    nxt = (m_ptr == NR - 1 || m_ptr == MAXP) ? 0 : m_ptr + 1;
    if (s || p || (adv && !l && nxt == 0))
      for (int k = 0; k < NT; k++) m_sh[k] = m_live[k];
    if (l) m_ptr = d % (1 << AW);
    else if (adv) m_ptr = nxt;
    if (w) begin m_pend = 1'b1; m_pd = d; end
    else if (a) m_pend = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    start = 0; stop = 0; ld = 0; wb = 0; ak = 0; rb = 0; din = 0; live = '0;
    for (int k = 0; k < NT; k++) m_sh[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    step(0,0,0,0,0,0,0,"R1");
    step(0,0,0,0,0,0,0,"R1");
    // R3: live changes but shadow not refreshed yet
    step(0,0,0,0,0,0,0,"R3");
    // R4: start refreshes shadow
    step(1,0,0,0,0,0,0,"R4");
    // R3/R5: snapshot read over time registers while live keeps changing
    for (int i = 0; i < NT; i++) step(0,0,0,0,0,1,0,"R3_R5");
    // R9: alarm range reads live
    for (int i = NT; i < NR - 1; i++) step(0,0,0,0,0,1,0,"R9");
    // R5: wrap from N_REG-1 to 0 refreshes shadow
    step(0,0,0,0,0,1,0,"R5");
    step(0,0,0,0,0,0,0,"R5");
    // R4: stop refreshes
    step(0,1,0,0,0,0,0,"R4");
    step(0,0,0,0,0,0,0,"R4");
    // R2: pointer load, and load priority over increment
    step(0,0,1,0,0,0,3,"R2");
    step(0,0,1,0,0,1,9,"R2");
    step(0,0,0,0,0,0,0,"R2");
    // R6/R7: write to seconds commits on ack, with divider reset
    step(1,0,0,0,0,0,0,"R4");
    step(0,0,1,0,0,0,0,"R2");
    step(0,0,0,1,0,0,8'h45,"R6");
    step(0,0,0,0,0,0,0,"R6");
    step(0,0,0,0,1,0,0,"R6_R7");
    step(0,0,0,1,0,0,8'h12,"R6");
    step(0,0,0,0,1,0,0,"R6");
    // R10: ack without pending byte
    step(0,0,0,0,1,0,0,"R10");
    step(0,0,0,0,0,0,0,"R10");
    // R7: commit to non-zero address keeps divider reset low
    step(0,0,1,0,0,0,NR-1,"R2");
    step(0,0,0,1,0,0,8'hA5,"R6");
    step(0,0,0,0,1,0,0,"R7");
    step(0,0,0,0,0,0,0,"R5");
    // R8: unimplemented addresses
    step(0,0,1,0,0,0,NR,"R2");
    step(0,0,0,1,0,0,8'h77,"R8");
    step(0,0,0,0,1,0,0,"R8");
    step(0,0,0,0,0,0,0,"R8");
    step(0,0,0,0,0,1,0,"R8_R5");
    step(0,0,0,0,0,0,0,"R5");
    step(0,1,0,0,0,0,0,"R4");
    step(0,0,0,0,0,0,0,"R3");
    done = 1'b1;
    finish_run();
  end
endmodule